// File: doc/BRIEF.md
# Bidirectional Pin Port with Peripheral Override

This block controls eight bidirectional pins. Each pin has an output latch and a direction bit. A peripheral can also take over the pin through a per-bit override. Software reaches the latch and the direction bits through a small register bus with one address bit. The pins are sampled through a two-flop synchronizer before software can read them.

The value a read of the data address returns depends on the access. An ordinary read shows the synchronized pin level on bits configured as inputs and the latch on bits configured as outputs. A read marked as the read phase of a read-modify-write returns the latch on every bit. Because of this, a bit-wise update that software makes by read, modify and write back never copies pin levels into the latch.

For each pin the block drives an output value and an output enable. An enabled override routes the peripheral's value to the pin. Otherwise an output bit drives its latch value and an input bit is left undriven.

Top module: `pin_port_ctrl`

## Requirements
- R1: After reset, the direction register reads 0, every output enable is 0 while no override is enabled, and the read data is 0.
- R2: A write with byte-enable 1 to address 0 loads the whole data latch, for input bits as well as output bits. A bit that is an input with its override disabled keeps its output enable at 0 after that write.
- R3: A bit whose direction is 1 (output) and whose override is disabled drives its latch value on its pin output, with the output enable at 1.
- R4: An ordinary read (read-modify-write flag 0) of address 0 returns, on bits whose direction is 0, the pin level sampled two clocks before the read strobe. This holds whether or not the bit's override is enabled.
- R5: An ordinary read of address 0 returns the latch value on bits whose direction is 1, whatever level the pin has.
- R6: A read of address 0 with the read-modify-write flag set returns the latch value on every bit, whatever the direction, override or pin state.
- R7: A bit whose override is enabled drives the peripheral's value on its pin output with the output enable at 1, whatever its direction.
- R8: A bit whose direction is 0 and whose override is disabled has its output enable at 0.
- R9: Read data appears on the clock edge after the read strobe and holds its value until the next read strobe.
- R10: A write with byte-enable 0 changes neither the latch nor the direction register.
- R11: A write with byte-enable 1 to address 1 loads the direction register. A read of address 1 returns the direction register whatever the read-modify-write flag is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register select: 0 = data latch, 1 = direction |
| bus_wr | input | 1 | Write strobe |
| bus_be | input | 1 | Byte-enable for the write |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rmw | input | 1 | Marks the read as the read phase of a read-modify-write |
| bus_rdata | output | 8 | Registered read data |
| periph_en | input | 8 | Per-bit peripheral override enable |
| periph_out | input | 8 | Per-bit peripheral output value |
| pin_in | input | 8 | Pin levels, asynchronous |
| pin_out | output | 8 | Per-pin output value |
| pin_oe | output | 8 | Per-pin output enable |

## Verification
The assertions assume that the bus strobes and the override inputs are synchronous to the clock. They also assume that a read strobe and a write strobe are not asserted in the same cycle, so that each check that a read returns the latch compares against a latch that was not changing. The stimulus changes inputs only on the falling clock edge and issues one bus operation at a time. Whenever it changes the pin levels outside the synchronizer timing test, it waits three clocks before any read, so that the expected level is known without modelling the synchronizer.

// File: rtl/pin_port_pkg.sv
package pin_port_pkg;

    // Register select decoded from the single bus address bit
    typedef enum logic {
        SEL_LATCH = 1'b0,
        SEL_DIR   = 1'b1
    } port_sel_e;

endpackage

// File: rtl/pin_port_regs.sv
module pin_port_regs
    import pin_port_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic         be,
    input  port_sel_e    sel,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] latch,
    output logic [W-1:0] dir
);

    typedef struct packed {
        logic [W-1:0] latch;
        logic [W-1:0] dir;
    } regs_t;

    regs_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr && be) begin
            if (sel == SEL_LATCH) begin
                s_d.latch = wdata;
            end else begin
                s_d.dir = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign latch = s_q.latch;
    assign dir   = s_q.dir;

    // R10: a write without byte-enable changes no register
    a_r10_be_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !be) |=> ($stable(latch) && $stable(dir)));

    // R2: an enabled write to the data address lands in the latch
    a_r2_latch_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && be && sel == SEL_LATCH) |=> (latch == $past(wdata)));

    // R11: an enabled write to the direction address lands in the direction register
    a_r11_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && be && sel == SEL_DIR) |=> (dir == $past(wdata)));

endmodule

// File: rtl/pin_port_sync.sv
module pin_port_sync #(
    parameter int unsigned W      = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    typedef struct packed {
        logic [STAGES-1:0][W-1:0] chain;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.chain[0] = async_in;
        for (int k = 1; k < STAGES; k++) begin
            s_d.chain[k] = s_q.chain[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign sync_out = s_q.chain[STAGES-1];

endmodule

// File: rtl/pin_port_readmux.sv
module pin_port_readmux
    import pin_port_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rd,
    input  logic         rmw,
    input  port_sel_e    sel,
    input  logic [W-1:0] latch,
    input  logic [W-1:0] dir,
    input  logic [W-1:0] pin_sync,
    output logic [W-1:0] rdata
);

    typedef struct packed {
        logic [W-1:0] rdata;
    } rd_t;

    rd_t          s_d, s_q;
    logic [W-1:0] data_view;

    // Per bit: read-modify-write or output direction shows the latch,
    // an ordinary read of an input shows the synchronized pin
    for (genvar i = 0; i < W; i++) begin : g_view
        assign data_view[i] = (rmw || dir[i]) ? latch[i] : pin_sync[i];
    end

    always_comb begin
        s_d = s_q;
        if (rd) begin
            s_d.rdata = (sel == SEL_DIR) ? dir : data_view;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rdata = s_q.rdata;

    // R6: a read-modify-write read of the data address returns the latch
    a_r6_rmw_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && rmw && sel == SEL_LATCH) |=> (rdata == $past(latch)));

    // R9: read data holds between read strobes
    a_r9_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(rdata));

    // R5: output bits read back the latch on an ordinary read
    a_r5_out_bits_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !rmw && sel == SEL_LATCH) |=> ((rdata & $past(dir)) == ($past(latch) & $past(dir))));

endmodule

// File: rtl/pin_port_drive.sv
module pin_port_drive #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] latch,
    input  logic [W-1:0] dir,
    input  logic [W-1:0] periph_en,
    input  logic [W-1:0] periph_out,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_oe
);

    for (genvar i = 0; i < W; i++) begin : g_pin
        assign pin_out[i] = periph_en[i] ? periph_out[i] : latch[i];
        assign pin_oe[i]  = periph_en[i] | dir[i];
    end

endmodule

// File: rtl/pin_port_ctrl.sv
module pin_port_ctrl
    import pin_port_pkg::*;
#(
    parameter int unsigned WIDTH       = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic             bus_be,
    input  logic [WIDTH-1:0] bus_wdata,
    input  logic             bus_rd,
    input  logic             bus_rmw,
    output logic [WIDTH-1:0] bus_rdata,
    input  logic [WIDTH-1:0] periph_en,
    input  logic [WIDTH-1:0] periph_out,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pin_out,
    output logic [WIDTH-1:0] pin_oe
);

    port_sel_e        sel;
    logic [WIDTH-1:0] latch;
    logic [WIDTH-1:0] dir;
    logic [WIDTH-1:0] pin_sync;

    assign sel = port_sel_e'(bus_sel);

    pin_port_regs #(.W(WIDTH)) i_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (bus_wr),
        .be    (bus_be),
        .sel   (sel),
        .wdata (bus_wdata),
        .latch (latch),
        .dir   (dir)
    );

    pin_port_sync #(.W(WIDTH), .STAGES(SYNC_STAGES)) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    pin_port_readmux #(.W(WIDTH)) i_readmux (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd       (bus_rd),
        .rmw      (bus_rmw),
        .sel      (sel),
        .latch    (latch),
        .dir      (dir),
        .pin_sync (pin_sync),
        .rdata    (bus_rdata)
    );

    pin_port_drive #(.W(WIDTH)) i_drive (
        .latch      (latch),
        .dir        (dir),
        .periph_en  (periph_en),
        .periph_out (periph_out),
        .pin_out    (pin_out),
        .pin_oe     (pin_oe)
    );

    // R8: with no override and all bits inputs, nothing is driven
    a_r8_inputs_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (dir == '0 && periph_en == '0) |-> (pin_oe == '0));

    // R3: an output bit without override drives the latch after a data write
    a_r3_out_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_be && sel == SEL_LATCH) |=> (((pin_out ^ latch) & dir & ~periph_en) == '0));

endmodule

// File: tb/test_pin_port_ctrl.sv
module test_pin_port_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_be = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic       bus_rd = 1'b0;
    logic       bus_rmw = 1'b0;
    logic [7:0] bus_rdata;
    logic [7:0] periph_en = '0;
    logic [7:0] periph_out = '0;
    logic [7:0] pin_in = '0;
    logic [7:0] pin_out;
    logic [7:0] pin_oe;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    logic [7:0] m_latch = '0;
    logic [7:0] m_dir   = '0;

    always #2.5 clk = ~clk;

    pin_port_ctrl i_pin_port_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_be     (bus_be),
        .bus_wdata  (bus_wdata),
        .bus_rd     (bus_rd),
        .bus_rmw    (bus_rmw),
        .bus_rdata  (bus_rdata),
        .periph_en  (periph_en),
        .periph_out (periph_out),
        .pin_in     (pin_in),
        .pin_out    (pin_out),
        .pin_oe     (pin_oe)
    );

    function automatic logic [7:0] f_read(input logic rmw, input logic [7:0] dir,
                                          input logic [7:0] lat, input logic [7:0] pin);
        return rmw ? lat : ((dir & lat) | (~dir & pin));
    endfunction

    function automatic logic [7:0] f_oe(input logic [7:0] dir, input logic [7:0] pen);
        return dir | pen;
    endfunction

    function automatic logic [7:0] f_out(input logic [7:0] lat, input logic [7:0] pen,
                                         input logic [7:0] pout);
        return (pen & pout) | (~pen & lat);
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic chk_pins();
        logic [7:0] oe_e;
        oe_e = f_oe(m_dir, periph_en);
        chk("R7/R8 pin_oe", pin_oe, oe_e);
        chk("R3/R7 pin_out", pin_out & oe_e, f_out(m_latch, periph_en, periph_out) & oe_e);
    endtask

    task automatic do_write(input logic sel, input logic [7:0] d, input logic be);
        @(negedge clk);
        bus_sel = sel; bus_wdata = d; bus_be = be; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_be = 1'b0;
        if (be) begin
            if (sel) m_dir = d; else m_latch = d;
        end
    endtask

    task automatic do_read(input logic sel, input logic rmw, output logic [7:0] d);
        @(negedge clk);
        bus_sel = sel; bus_rmw = rmw; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0; bus_rmw = 1'b0;
        d = bus_rdata;
    endtask

    task automatic set_pins(input logic [7:0] p);
        @(negedge clk);
        pin_in = p;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        int cyc = 0;
        while (!finished) begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000 && !finished) begin
                n_checks++;
                n_fail++;
                $display("FAIL watchdog actual=%0d expected<100000", cyc);
                $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
                $finish;
            end
        end
    end

    initial begin
        logic [7:0] rd_v;
        logic [7:0] held;
        void'($urandom(32'd4711));

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 rdata", bus_rdata, 8'h00);
        chk("R1 pin_oe", pin_oe, 8'h00);
        do_read(1'b1, 1'b0, rd_v);
        chk("R1 dir", rd_v, 8'h00);

        // R2, R8: latch write with all bits as inputs
        do_write(1'b0, 8'hA5, 1'b1);
        chk("R2/R8 oe after latch write", pin_oe, 8'h00);
        set_pins(8'h3C);
        do_read(1'b0, 1'b0, rd_v);
        chk("R4 input read", rd_v, 8'h3C);
        do_read(1'b0, 1'b1, rd_v);
        chk("R6 rmw read", rd_v, 8'hA5);

        // R3, R5, R11
        do_write(1'b1, 8'hF0, 1'b1);
        do_read(1'b1, 1'b1, rd_v);
        chk("R11 dir read rmw", rd_v, 8'hF0);
        chk("R3 pin_oe", pin_oe, 8'hF0);
        chk("R3 pin_out", pin_out & 8'hF0, 8'hA0);
        do_read(1'b0, 1'b0, rd_v);
        chk("R5 mixed read", rd_v, 8'hAC);

        // R10: write without byte-enable to both addresses
        do_write(1'b0, 8'hFF, 1'b0);
        do_write(1'b1, 8'h0F, 1'b0);
        do_read(1'b0, 1'b1, rd_v);
        chk("R10 latch kept", rd_v, 8'hA5);
        do_read(1'b1, 1'b0, rd_v);
        chk("R10 dir kept", rd_v, 8'hF0);

        // R7 and R4 with override
        @(negedge clk);
        periph_en = 8'h0F; periph_out = 8'h05;
        #1;
        chk("R7 oe", pin_oe, 8'hFF);
        chk("R7 out", pin_out, 8'hA5);
        do_read(1'b0, 1'b0, rd_v);
        chk("R4 read with override", rd_v, 8'hAC);
        periph_en = 8'h00;

        // R9: read data holds while pins and latch change
        do_read(1'b0, 1'b0, held);
        set_pins(8'hC3);
        do_write(1'b0, 8'h5A, 1'b1);
        chk("R9 rdata hold", bus_rdata, held);

        // R4 timing: two-clock synchronizer delay
        do_write(1'b1, 8'h00, 1'b1);
        set_pins(8'h11);
        @(negedge clk);
        pin_in = 8'hEE; bus_sel = 1'b0; bus_rmw = 1'b0; bus_rd = 1'b1;
        @(negedge clk);
        chk("R4 delay 0", bus_rdata, 8'h11);
        @(negedge clk);
        chk("R4 delay 1", bus_rdata, 8'h11);
        @(negedge clk);
        bus_rd = 1'b0;
        chk("R4 delay 2", bus_rdata, 8'hEE);
        chk_pins();

        // Constrained random mix
        for (int it = 0; it < 400; it++) begin
            int op;
            op = $urandom_range(0, 6);
            case (op)
                0: do_write(1'b0, 8'($urandom), 1'b1);
                1: do_write(1'b1, 8'($urandom), 1'b1);
                2: do_write(1'($urandom), 8'($urandom), 1'b0);
                3: set_pins(8'($urandom));
                4: begin
                    @(negedge clk);
                    periph_en = 8'($urandom); periph_out = 8'($urandom);
                end
                5: begin
                    logic rmw_f;
                    rmw_f = 1'($urandom);
                    do_read(1'b0, rmw_f, rd_v);
                    chk(rmw_f ? "R6 random read" : "R4/R5 random read", rd_v,
                        f_read(rmw_f, m_dir, m_latch, pin_in));
                end
                default: begin
                    do_read(1'b1, 1'($urandom), rd_v);
                    chk("R11 random dir read", rd_v, m_dir);
                end
            endcase
            #1;
            chk_pins();
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule